// File: doc/BRIEF.md
# SCSI DMA Address and Control Glue

This block sits between a host byte bus and an ESP-style SCSI chip on a controller board. The host uses it for three things. It sets the interrupt enable, the DMA enable, the transfer direction and the LED through one control byte. It reads back three status bits from the same location. It arms a 32-bit DMA address by first writing a reset location and then writing the four address bytes. Once the address is armed and DMA is enabled, the chip's byte stream is converted to and from 16-bit big-endian memory words. The pointer advances by two bytes for each word.

The board interrupt comes from the chip's interrupt line gated by the interrupt enable. The status byte reports this with mixed polarity: an active-high request bit and an active-low interrupt bit. A sticky error flag records any chip request whose direction disagrees with the programmed one. A one-cycle done pulse marks the byte the chip flags as last. Host address map, in byte addresses of an 8-bit host address: 0x00–0x3F load address bytes (low two bits select the lane), 0x40 is control/status, 0x80 is the DMA reset.

Top module: `scsi_dma_glue`

## Requirements
- R1: After reset, a read of 0x40 returns 0x80, board_irq, led, dma_err and xfer_done are 0, and mem_addr is 0.
- R2: A write to 0x40 stores led (bit4), memory-to-chip direction (bit3), DMA enable (bit2) and interrupt enable (bit0); bits 7:5 and bit1 have no effect. A read of 0x40 returns {irq_n, active, req, 5'b00000}, where active is 1 while DMA runs. The led port follows bit4.
- R3: A write to 0x80 sets mem_addr to 0, arms a byte-load count of 4, stops any running DMA and clears dma_err.
- R4: A write to an address in 0x00–0x3F stores the data in the pointer byte selected by address bits 1:0. Lane 0 goes to bits 31:24, lane 1 to 23:16, lane 2 to 15:8 and lane 3 to 7:0. Each such write lowers a nonzero count by one.
- R5: When the count reaches zero while DMA is enabled, DMA starts. Loads made after the count is already zero start nothing.
- R6: A 0-to-1 change of the DMA-enable bit starts DMA, and a 1-to-0 change stops it.
- R7: One clock after chip_irq is 1 with the interrupt enable set, board_irq is 1 and the status reads req=1, irq_n=0. Otherwise board_irq is 0 and the status reads req=0, irq_n=1. Control bit1 does not affect the interrupt.
- R8: Memory to chip: the word at the even pointer is delivered as its high byte, then its low byte. The pointer grows by 2 after the low byte, or after the high byte if chip_last is set with it.
- R9: Chip to memory: two bytes form one word, with the first byte high, written with mem_be=2'b11. A final odd byte is written as the high byte with mem_be=2'b10. The pointer grows by 2 per write.
- R10: A chip request whose chip_dir differs from control bit3 is not acknowledged and sets dma_err, which holds until a write to 0x80.
- R11: xfer_done is high for exactly the one clock after the byte flagged by chip_last is accepted.
- R12: While DMA is not running, chip requests are not acknowledged and mem_addr does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host byte write strobe |
| host_addr | input | HOST_AW | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Status byte when host_addr is 0x40, else 0 |
| chip_irq | input | 1 | Interrupt from the SCSI chip |
| board_irq | output | 1 | Gated board interrupt |
| led | output | 1 | Activity LED from control bit4 |
| chip_req | input | 1 | Chip offers or wants one byte |
| chip_dir | input | 1 | 1 = chip reads from memory, 0 = chip writes to memory |
| chip_last | input | 1 | Current byte is the last of the transfer |
| chip_wdata | input | 8 | Byte from the chip |
| chip_ack | output | 1 | Byte accepted in this cycle |
| chip_rdata | output | 8 | Byte to the chip, valid with chip_ack |
| mem_addr | output | PTR_W | Even word address of the DMA pointer |
| mem_re | output | 1 | Word read strobe, data expected in the same cycle |
| mem_rdata | input | 16 | Word read data |
| mem_we | output | 1 | Word write strobe |
| mem_be | output | 2 | Byte enables, bit1 = high byte |
| mem_wdata | output | 16 | Word write data |
| dma_err | output | 1 | Sticky direction-mismatch flag |
| xfer_done | output | 1 | One-clock pulse after the last byte |

## Verification
Register and pointer effects of a host write appear right after the writing edge, so the bench checks them at the next falling edge. The interrupt path has one extra register, so board_irq and the req/irq_n status are checked one clock after chip_irq or the enable changes, and also sampled just before that edge to confirm they have not yet moved. chip_ack and chip_rdata are combinational on the request, so they are checked in the same low phase the request is driven. The advanced pointer, the written memory word and xfer_done are checked at the falling edge after the accepting edge.

// File: rtl/scsi_glue_pkg.sv
package scsi_glue_pkg;

    localparam int HOST_AW_DEF = 8;
    localparam int PTR_W_DEF   = 32;
    localparam int BYTE_W      = 8;
    localparam int WORD_W      = 16;

    // stored control fields (bit1 and bits 7:5 of the written byte are dropped)
    typedef struct packed {
        logic led;
        logic dir_m2c;
        logic dma_en;
        logic irq_en;
    } ctrl_t;

    // visible status, msb first: interrupt-not, active, request
    typedef struct packed {
        logic irq_n;
        logic active;
        logic req;
    } stat_t;

    typedef enum logic {
        PH_HI = 1'b0,
        PH_LO = 1'b1
    } phase_e;

    function automatic logic [7:0] stat_byte(input stat_t s);
        return {s, 5'b00000};
    endfunction

endpackage

// File: rtl/scsi_glue_regs.sv
module scsi_glue_regs
    import scsi_glue_pkg::*;
#(
    parameter int HOST_AW = HOST_AW_DEF,
    parameter int PTR_W   = PTR_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [7:0]         host_wdata,
    output logic [7:0]         host_rdata,
    input  logic               chip_irq,
    input  logic               ptr_inc,
    output logic [PTR_W-1:0]   ptr_o,
    output logic               run_o,
    output logic               dir_m2c_o,
    output logic               led_o,
    output logic               board_irq,
    output logic               drst_o
);
    localparam int BYTES  = PTR_W / BYTE_W;
    localparam int LANE_W = $clog2(BYTES);
    localparam int CNT_W  = $clog2(BYTES + 1);
    localparam logic [HOST_AW-1:0] CTRL_A = {2'b01, {(HOST_AW-2){1'b0}}};
    localparam logic [HOST_AW-1:0] DRST_A = {2'b10, {(HOST_AW-2){1'b0}}};

    ctrl_t             ctrl_q, ctrl_new;
    logic [PTR_W-1:0]  ptr_q, ptr_d;
    logic [CNT_W-1:0]  cnt_q;
    logic              run_q, irq_q;
    logic              sel_load, sel_ctrl, sel_drst, load_done;
    logic [BYTES-1:0]  lane_hit;
    stat_t             stat;

    assign sel_load  = host_wr && (host_addr[HOST_AW-1:HOST_AW-2] == 2'b00);
    assign sel_ctrl  = host_wr && (host_addr == CTRL_A);
    assign sel_drst  = host_wr && (host_addr == DRST_A);
    assign load_done = sel_load && (cnt_q == CNT_W'(1));

    assign ctrl_new = '{led:     host_wdata[4],
                        dir_m2c: host_wdata[3],
                        dma_en:  host_wdata[2],
                        irq_en:  host_wdata[0]};

    generate
        for (genvar g = 0; g < BYTES; g++) begin : g_lane
            assign lane_hit[g] = sel_load && (host_addr[LANE_W-1:0] == LANE_W'(g));
        end
    endgenerate

    always_comb begin
        ptr_d = ptr_q;
        if (sel_drst) begin
            ptr_d = '0;
        end else if (sel_load) begin
            for (int i = 0; i < BYTES; i++) begin
                if (lane_hit[i]) ptr_d[PTR_W-1-BYTE_W*i -: BYTE_W] = host_wdata;
            end
        end else if (ptr_inc) begin
            ptr_d = ptr_q + PTR_W'(2);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ptr_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            ptr_q <= ptr_d;
            irq_q <= chip_irq && ctrl_q.irq_en;
            if (sel_drst) begin
                cnt_q <= CNT_W'(BYTES);
                run_q <= 1'b0;
            end else if (sel_load) begin
                if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
                if (load_done && ctrl_q.dma_en) run_q <= 1'b1;
            end else if (sel_ctrl) begin
                ctrl_q <= ctrl_new;
                if (!ctrl_q.dma_en && ctrl_new.dma_en) run_q <= 1'b1;
                else if (ctrl_q.dma_en && !ctrl_new.dma_en) run_q <= 1'b0;
            end
        end
    end

    assign stat       = '{irq_n: !irq_q, active: run_q, req: irq_q};
    assign host_rdata = (host_addr == CTRL_A) ? stat_byte(stat) : 8'h00;
    assign ptr_o      = ptr_q;
    assign run_o      = run_q;
    assign dir_m2c_o  = ctrl_q.dir_m2c;
    assign led_o      = ctrl_q.led;
    assign board_irq  = irq_q;
    assign drst_o     = sel_drst;

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(BYTES)); // R3
    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(run_q) |-> ctrl_q.dma_en); // R5
    AST_STOP_ON_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl_q.dma_en) |-> !run_q); // R6
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> $past(ctrl_q.irq_en)); // R7
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (ptr_inc && !sel_load && !sel_drst) |=> ptr_q == $past(ptr_q) + PTR_W'(2)); // R8

endmodule

// File: rtl/scsi_glue_xfer.sv
module scsi_glue_xfer
    import scsi_glue_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              dir_m2c,
    input  logic              clr,
    input  logic              chip_req,
    input  logic              chip_dir,
    input  logic              chip_last,
    input  logic [BYTE_W-1:0] chip_wdata,
    output logic              chip_ack,
    output logic [BYTE_W-1:0] chip_rdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_re,
    output logic              mem_we,
    output logic [1:0]        mem_be,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              ptr_inc,
    output logic              err,
    output logic              done
);
    phase_e            phase_q;
    logic [BYTE_W-1:0] hold_q;
    logic              err_q, done_q;
    logic              accept, refuse;

    assign accept = run && chip_req && (chip_dir == dir_m2c);
    assign refuse = run && chip_req && (chip_dir != dir_m2c);

    always_comb begin
        chip_ack   = accept;
        chip_rdata = (phase_q == PH_LO) ? hold_q : mem_rdata[WORD_W-1:BYTE_W];
        mem_re     = 1'b0;
        mem_we     = 1'b0;
        mem_be     = 2'b00;
        mem_wdata  = '0;
        ptr_inc    = 1'b0;
        if (accept) begin
            if (dir_m2c) begin
                mem_re  = (phase_q == PH_HI);
                ptr_inc = (phase_q == PH_LO) || chip_last;
            end else if (phase_q == PH_LO) begin
                mem_we    = 1'b1;
                mem_be    = 2'b11;
                mem_wdata = {hold_q, chip_wdata};
                ptr_inc   = 1'b1;
            end else if (chip_last) begin
                mem_we    = 1'b1;
                mem_be    = 2'b10;
                mem_wdata = {chip_wdata, {BYTE_W{1'b0}}};
                ptr_inc   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase_q <= PH_HI;
            hold_q  <= '0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= accept && chip_last;
            if (refuse) err_q <= 1'b1;
            if (accept) begin
                if (phase_q == PH_HI && !chip_last) begin
                    phase_q <= PH_LO;
                    hold_q  <= dir_m2c ? mem_rdata[BYTE_W-1:0] : chip_wdata;
                end else begin
                    phase_q <= PH_HI;
                end
            end
        end
    end

    assign err  = err_q;
    assign done = done_q;

    AST_ACK_DIR_MATCH: assert property (@(posedge clk) disable iff (rst)
        chip_ack |-> (chip_dir == dir_m2c)); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_q && !clr) |=> err_q); // R10
    AST_NO_IDLE_ACK: assert property (@(posedge clk) disable iff (rst)
        !run |-> !chip_ack); // R12
    AST_ONE_MEM_OP: assert property (@(posedge clk) disable iff (rst)
        !(mem_re && mem_we)); // R9

endmodule

// File: rtl/scsi_dma_glue.sv
module scsi_dma_glue
    import scsi_glue_pkg::*;
#(
    parameter int HOST_AW = HOST_AW_DEF,
    parameter int PTR_W   = PTR_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [7:0]         host_wdata,
    output logic [7:0]         host_rdata,
    input  logic               chip_irq,
    output logic               board_irq,
    output logic               led,
    input  logic               chip_req,
    input  logic               chip_dir,
    input  logic               chip_last,
    input  logic [7:0]         chip_wdata,
    output logic               chip_ack,
    output logic [7:0]         chip_rdata,
    output logic [PTR_W-1:0]   mem_addr,
    output logic               mem_re,
    input  logic [15:0]        mem_rdata,
    output logic               mem_we,
    output logic [1:0]         mem_be,
    output logic [15:0]        mem_wdata,
    output logic               dma_err,
    output logic               xfer_done
);
    logic [PTR_W-1:0] ptr;
    logic             run, dir_m2c, drst, ptr_inc;

    scsi_glue_regs #(.HOST_AW(HOST_AW), .PTR_W(PTR_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .chip_irq   (chip_irq),
        .ptr_inc    (ptr_inc),
        .ptr_o      (ptr),
        .run_o      (run),
        .dir_m2c_o  (dir_m2c),
        .led_o      (led),
        .board_irq  (board_irq),
        .drst_o     (drst)
    );

    scsi_glue_xfer u_xfer (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .dir_m2c    (dir_m2c),
        .clr        (drst),
        .chip_req   (chip_req),
        .chip_dir   (chip_dir),
        .chip_last  (chip_last),
        .chip_wdata (chip_wdata),
        .chip_ack   (chip_ack),
        .chip_rdata (chip_rdata),
        .mem_rdata  (mem_rdata),
        .mem_re     (mem_re),
        .mem_we     (mem_we),
        .mem_be     (mem_be),
        .mem_wdata  (mem_wdata),
        .ptr_inc    (ptr_inc),
        .err        (dma_err),
        .done       (xfer_done)
    );

    assign mem_addr = {ptr[PTR_W-1:1], 1'b0};

endmodule

// File: tb/tb_scsi_dma_glue.sv
module tb_scsi_dma_glue;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [7:0]  host_addr = 8'h40;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  host_rdata;
    logic        chip_irq = 1'b0;
    logic        board_irq, led;
    logic        chip_req = 1'b0, chip_dir = 1'b0, chip_last = 1'b0;
    logic [7:0]  chip_wdata = 8'h00;
    logic        chip_ack;
    logic [7:0]  chip_rdata;
    logic [31:0] mem_addr;
    logic        mem_re, mem_we;
    logic [15:0] mem_rdata, mem_wdata;
    logic [1:0]  mem_be;
    logic        dma_err, xfer_done;

    logic [15:0] mem [0:63];
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scsi_dma_glue dut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .chip_irq(chip_irq),
        .board_irq(board_irq), .led(led), .chip_req(chip_req), .chip_dir(chip_dir),
        .chip_last(chip_last), .chip_wdata(chip_wdata), .chip_ack(chip_ack),
        .chip_rdata(chip_rdata), .mem_addr(mem_addr), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .dma_err(dma_err), .xfer_done(xfer_done)
    );

    // word memory: byte at address a holds a, big-endian words
    assign mem_rdata = mem[mem_addr[6:1]];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) mem[i] <= {8'(2*i), 8'(2*i+1)};
        end else if (mem_we) begin
            if (mem_be[1]) mem[mem_addr[6:1]][15:8] <= mem_wdata[15:8];
            if (mem_be[0]) mem[mem_addr[6:1]][7:0]  <= mem_wdata[7:0];
        end
    end

    // {write data, expected status read}, chip_irq low
    localparam logic [15:0] CTRL_VEC [6] = '{
        16'h0080, 16'h1080, 16'h04C0, 16'h1CC0, 16'h0880, 16'hE380
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_addr = 8'h40;
        #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic chip_byte(input string req, input logic dir, input logic last,
                             input logic [7:0] wd, input logic exp_ack,
                             input logic chk_rd, input logic [7:0] exp_rd);
        @(negedge clk);
        chip_req = 1'b1; chip_dir = dir; chip_last = last; chip_wdata = wd;
        #1;
        chk(req, 32'(chip_ack), 32'(exp_ack));
        if (chk_rd) chk(req, 32'(chip_rdata), 32'(exp_rd));
        @(negedge clk);
        chip_req = 1'b0; chip_last = 1'b0;
        #1;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        // R1 reset state
        chk("R1", 32'(host_rdata), 32'h80);
        chk("R1", 32'(board_irq), 0);
        chk("R1", 32'(led), 0);
        chk("R1", mem_addr, 0);
        chk("R1", 32'(dma_err), 0);
        chk("R1", 32'(xfer_done), 0);

        // R2 / R6 control table
        for (int i = 0; i < 6; i++) begin
            hwrite(8'h40, CTRL_VEC[i][15:8]);
            idle(1);
            chk("R2", 32'(host_rdata), 32'(CTRL_VEC[i][7:0]));
            chk("R2", 32'(led), 32'(CTRL_VEC[i][12]));
        end

        // R7 interrupt path, one clock latency (ctrl holds 0xE3: irq_en=1)
        @(negedge clk); chip_irq = 1'b1; #1;
        chk("R7", 32'(board_irq), 0);
        idle(1);
        chk("R7", 32'(board_irq), 1);
        chk("R7", 32'(host_rdata), 32'h20);
        hwrite(8'h40, 8'h02);
        idle(1);
        chk("R7", 32'(board_irq), 0);
        chk("R7", 32'(host_rdata), 32'h80);
        @(negedge clk); chip_irq = 1'b0; #1;

        // R4 lane order, R3 reset of pointer
        hwrite(8'h80, 8'h00);
        hwrite(8'h00, 8'h12);
        hwrite(8'h01, 8'h34);
        hwrite(8'h02, 8'h56);
        hwrite(8'h03, 8'h78);
        chk("R4", mem_addr, 32'h12345678);
        chk("R5", 32'(host_rdata), 32'h80);
        hwrite(8'h03, 8'h9A);
        chk("R4", mem_addr, 32'h1234569A);
        hwrite(8'h80, 8'h00);
        chk("R3", mem_addr, 0);

        // R5 start on count reaching zero, R3 stop by reset write
        hwrite(8'h40, 8'h04);
        chk("R6", 32'(host_rdata), 32'hC0);
        hwrite(8'h80, 8'h00);
        chk("R3", 32'(host_rdata), 32'h80);
        hwrite(8'h00, 8'h00);
        hwrite(8'h01, 8'h00);
        hwrite(8'h02, 8'h00);
        chk("R5", 32'(host_rdata), 32'h80);
        hwrite(8'h03, 8'h10);
        chk("R5", 32'(host_rdata), 32'hC0);
        chk("R5", mem_addr, 32'h10);

        // R8 memory to chip, R11 done pulse
        hwrite(8'h40, 8'h0C);
        chip_byte("R8", 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 8'h10);
        chk("R8", mem_addr, 32'h10);
        chip_byte("R8", 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 8'h11);
        chk("R8", mem_addr, 32'h12);
        chk("R11", 32'(xfer_done), 0);
        chip_byte("R8", 1'b1, 1'b1, 8'h00, 1'b1, 1'b1, 8'h12);
        chk("R11", 32'(xfer_done), 1);
        chk("R8", mem_addr, 32'h14);
        idle(1);
        chk("R11", 32'(xfer_done), 0);

        // R9 chip to memory with odd final byte
        hwrite(8'h40, 8'h04);
        hwrite(8'h80, 8'h00);
        hwrite(8'h00, 8'h00);
        hwrite(8'h01, 8'h00);
        hwrite(8'h02, 8'h00);
        hwrite(8'h03, 8'h20);
        chip_byte("R9", 1'b0, 1'b0, 8'h11, 1'b1, 1'b0, 8'h00);
        chip_byte("R9", 1'b0, 1'b0, 8'h22, 1'b1, 1'b0, 8'h00);
        chk("R9", 32'(mem[16]), 32'h1122);
        chip_byte("R9", 1'b0, 1'b1, 8'h33, 1'b1, 1'b0, 8'h00);
        chk("R9", 32'(mem[17]), 32'h3323);
        chk("R9", mem_addr, 32'h24);

        // R10 direction mismatch
        chip_byte("R10", 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
        chk("R10", 32'(dma_err), 1);
        chk("R10", mem_addr, 32'h24);
        idle(2);
        chk("R10", 32'(dma_err), 1);
        hwrite(8'h80, 8'h00);
        chk("R10", 32'(dma_err), 0);

        // R12 idle DMA ignores requests
        chip_byte("R12", 1'b0, 1'b0, 8'h55, 1'b0, 1'b0, 8'h00);
        chk("R12", mem_addr, 0);
        chk("R12", 32'(mem[0]), 32'h0001);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule